// File: doc/BRIEF.md
# Cycle-Timed Unsigned 32/16 Divider

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor. It returns a 16-bit quotient and a 16-bit remainder. It is meant to sit beside a sequencer that must keep the timing of an older microcoded machine. The block therefore does not finish as soon as the arithmetic is ready. It holds its done strobe back for a data-dependent number of clocks that follows a restoring-division cost model, counted in two-clock micro-cycles.

Three outcomes are possible. A zero divisor finishes at once with a divide-by-zero flag. When the upper half of the dividend is not below the divisor, the quotient cannot fit, so the block takes a short fixed exit and raises an overflow flag. Any other operand pair runs the timed path. On that path the quotient is produced by a one-bit-per-clock restoring divider. In parallel, a separate 15-step model adds up the micro-cycle cost. A debug output reports the cost figure that an instruction sequencer would add to its own fixed overhead.

Top module: `udiv32_timed`

## Requirements
- R1: With `divisor` equal to zero, `done` and `div_zero` are high in the first cycle after the clock edge that accepts `start`. In that cycle `overflow` is 0 and `cycle_count` is 0, and `quotient` and `remainder` keep their previous values.
- R2: When `divisor` is nonzero and `dividend[31:16] >= divisor`, the operation is an overflow. `done` and `overflow` are high in the 10th cycle after the accepting edge, and `cycle_count` is 6. `quotient` and `remainder` keep their previous values.
- R3: In every other case, on `done` the block gives `quotient = dividend / divisor` and `remainder = dividend % divisor`. `result` carries the remainder in bits 31:16 and the quotient in bits 15:0.
- R4: For the non-overflow case, the cost M in micro-cycles is worked out as follows. Start with W = dividend, D = divisor shifted left by 16, and M = 38. Then repeat 15 times: take S = W shifted left by 1. If bit 31 of W was 1, set W = S - D. Otherwise add 2 to M; if S >= D, set W = S - D and subtract 1 from M; if not, set W = S. `done` is high in cycle 2*M after the accepting edge.
- R5: On `done`, `cycle_count` equals 2*M - 4. For non-overflow divisions, 2*M lies between 76 and 136 inclusive. Dividend 0 with divisor 1 gives the largest case, 136.
- R6: `done` is high for exactly one cycle. `div_zero` and `overflow` describe the operation that last completed, and they change only when `done` is high.
- R7: A `start` seen while an operation is in flight is ignored. The running operation finishes with its own timing and results, and no extra `done` follows.
- R8: While `rst` is high, and after it falls, every output is 0 until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| dividend | input | 32 | Unsigned dividend, sampled with start |
| divisor | input | 16 | Unsigned divisor, sampled with start |
| quotient | output | 16 | Quotient of the last timed division |
| remainder | output | 16 | Remainder of the last timed division |
| result | output | 32 | Remainder in 31:16, quotient in 15:0 |
| div_zero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last operation overflowed |
| done | output | 1 | One-cycle completion strobe |
| cycle_count | output | 8 | Debug: cost figure of the last operation (2*M - 4) |

## Verification
A wrong step in the cost model never changes the quotient. It shows only as a `done` that arrives some clocks early or late, and as a `cycle_count` that is off by the same amount. Both appear at the end of the operation, between 76 and 136 clocks after start. For that reason every timed case measures its latency in whole clocks against the model. A fault in the restoring divider shows up at that same `done` as a wrong quotient or remainder. A wrong early-exit decision shows within ten clocks, either as a flag with the wrong latency or as overwritten results that should have been held.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;
  localparam int MICRO_BASE  = 38;
  localparam int OVF_CLOCKS  = 10;
  localparam int REPORT_ADJ  = 4;
endpackage

// File: rtl/udiv_quot_unit.sv
module udiv_quot_unit #(
  parameter int DVS_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [2*DVS_W-1:0] dvd,
  input  logic [DVS_W-1:0]   dvs,
  output logic [DVS_W-1:0]   quo,
  output logic [DVS_W-1:0]   rem
);
  localparam int DVD_W = 2 * DVS_W;
  localparam int CW    = $clog2(DVS_W + 1);

  logic [DVS_W-1:0] part_r, low_bits, dv_r, q_r;
  logic [CW-1:0]    steps_left;
  logic [DVS_W:0]   trial;
  logic             take;

  always_comb begin
    trial = {part_r, low_bits[DVS_W-1]};
    take  = (trial >= {1'b0, dv_r});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part_r     <= '0;
      low_bits   <= '0;
      dv_r       <= '0;
      q_r        <= '0;
      steps_left <= '0;
    end else if (load) begin
      part_r     <= dvd[DVD_W-1:DVS_W];
      low_bits   <= dvd[DVS_W-1:0];
      dv_r       <= dvs;
      q_r        <= '0;
      steps_left <= CW'(DVS_W);
    end else if (steps_left != '0) begin
      if (take) part_r <= DVS_W'(trial - {1'b0, dv_r});
      else      part_r <= trial[DVS_W-1:0];
      q_r        <= {q_r[DVS_W-2:0], take};
      low_bits   <= {low_bits[DVS_W-2:0], 1'b0};
      steps_left <= steps_left - CW'(1);
    end
  end

  assign quo = q_r;
  assign rem = part_r;

  // R3: the partial remainder stays below the divisor while iterating
  a_r3_partial_rem: assert property (@(posedge clk) disable iff (rst)
    (steps_left != '0) |-> (part_r < dv_r));
endmodule

// File: rtl/udiv_cost_model.sv
module udiv_cost_model import udiv_pkg::*; #(
  parameter int DVS_W = 16,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [2*DVS_W-1:0] dvd,
  input  logic [DVS_W-1:0]   dvs,
  output logic [CNT_W-1:0]   micro,
  output logic               settled
);
  localparam int DVD_W = 2 * DVS_W;
  localparam int ITER  = DVS_W - 1;
  localparam int IW    = $clog2(ITER + 1);
  localparam int MAX_M = MICRO_BASE + 2 * ITER;

  logic [DVD_W-1:0] work, aligned, shifted;
  logic [IW-1:0]    left;

  always_comb shifted = work << 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      work    <= '0;
      aligned <= '0;
      micro   <= '0;
      left    <= '0;
      settled <= 1'b0;
    end else if (load) begin
      work    <= dvd;
      aligned <= {dvs, {DVS_W{1'b0}}};
      micro   <= CNT_W'(MICRO_BASE);
      left    <= IW'(ITER);
      settled <= 1'b0;
    end else if (left != '0) begin
      if (work[DVD_W-1]) begin
        work <= shifted - aligned;
      end else if (shifted >= aligned) begin
        work  <= shifted - aligned;
        micro <= micro + CNT_W'(1);
      end else begin
        work  <= shifted;
        micro <= micro + CNT_W'(2);
      end
      left <= left - IW'(1);
      if (left == IW'(1)) settled <= 1'b1;
    end
  end

  // R4: each model step adds 0, 1 or 2 micro-cycles
  a_r4_step_cost: assert property (@(posedge clk) disable iff (rst)
    (left != '0 && !load) |=> (micro >= $past(micro) && micro <= $past(micro) + CNT_W'(2)));
  // R5: a settled total lies within the base and the worst case
  a_r5_micro_bounds: assert property (@(posedge clk) disable iff (rst)
    settled |-> (micro >= CNT_W'(MICRO_BASE) && micro <= CNT_W'(MAX_M)));
endmodule

// File: rtl/udiv32_timed.sv
module udiv32_timed import udiv_pkg::*; #(
  parameter int DVS_W = 16,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2*DVS_W-1:0]   dividend,
  input  logic [DVS_W-1:0]     divisor,
  output logic [DVS_W-1:0]     quotient,
  output logic [DVS_W-1:0]     remainder,
  output logic [2*DVS_W-1:0]   result,
  output logic                 div_zero,
  output logic                 overflow,
  output logic                 done,
  output logic [CNT_W-1:0]     cycle_count
);
  localparam int DVD_W = 2 * DVS_W;

  seq_state_e       state;
  logic [CNT_W-1:0] elapsed, target, micro;
  logic [DVS_W-1:0] core_q, core_r;
  logic             ovf_path, settled, accept, is_zero, is_ovf, load_core, finish;

  always_comb begin
    accept    = start && (state == ST_IDLE);
    is_zero   = (divisor == '0);
    is_ovf    = (dividend[DVD_W-1:DVS_W] >= divisor);
    load_core = accept && !is_zero && !is_ovf;
    target    = ovf_path ? CNT_W'(OVF_CLOCKS) : CNT_W'({micro, 1'b0});
    finish    = (state == ST_RUN) && (ovf_path || settled) &&
                (elapsed == target - CNT_W'(1));
  end

  udiv_quot_unit #(.DVS_W(DVS_W)) u_quot (
    .clk(clk), .rst(rst), .load(load_core), .dvd(dividend), .dvs(divisor),
    .quo(core_q), .rem(core_r)
  );

  udiv_cost_model #(.DVS_W(DVS_W), .CNT_W(CNT_W)) u_cost (
    .clk(clk), .rst(rst), .load(load_core), .dvd(dividend), .dvs(divisor),
    .micro(micro), .settled(settled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      elapsed     <= '0;
      ovf_path    <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_zero    <= 1'b0;
      overflow    <= 1'b0;
      done        <= 1'b0;
      cycle_count <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (is_zero) begin
              done        <= 1'b1;
              div_zero    <= 1'b1;
              overflow    <= 1'b0;
              cycle_count <= '0;
            end else begin
              state    <= ST_RUN;
              elapsed  <= CNT_W'(1);
              ovf_path <= is_ovf;
            end
          end
        end
        ST_RUN: begin
          elapsed <= elapsed + CNT_W'(1);
          if (finish) begin
            state       <= ST_IDLE;
            done        <= 1'b1;
            div_zero    <= 1'b0;
            overflow    <= ovf_path;
            cycle_count <= target - CNT_W'(REPORT_ADJ);
            if (!ovf_path) begin
              quotient  <= core_q;
              remainder <= core_r;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign result = {remainder, quotient};

  // R6: completion strobe lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: flags move only together with done
  a_r6_flags_on_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(div_zero) && $stable(overflow)));
  // R1: zero divisor completes in the next cycle
  a_r1_zero_fast: assert property (@(posedge clk) disable iff (rst)
    (start && state == ST_IDLE && divisor == '0) |=> (done && div_zero));
  // R2: overflow leaves the results untouched
  a_r2_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> ($stable(quotient) && $stable(remainder)));
  // R5: reported cost of a timed division is within its range
  a_r5_count_range: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow && !div_zero) |-> (cycle_count >= CNT_W'(72) && cycle_count <= CNT_W'(132)));
  // R7: the chosen path is frozen while running
  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !finish) |=> (state == ST_RUN && ovf_path == $past(ovf_path)));
endmodule

// File: tb/sim_udiv32_timed.sv
`timescale 1ns/1ps
module sim_udiv32_timed;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic [15:0] quotient, remainder;
  logic [31:0] result;
  logic        div_zero, overflow, done;
  logic [7:0]  cycle_count;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  udiv32_timed u0 (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .result(result),
    .div_zero(div_zero), .overflow(overflow), .done(done), .cycle_count(cycle_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_micro(input logic [31:0] a, input logic [15:0] d);
    logic [31:0] w, hd, s;
    int m;
    w = a; hd = {d, 16'h0}; m = 38;
    for (int i = 0; i < 15; i++) begin
      s = w << 1;
      if (w[31]) w = s - hd;
      else begin
        m += 2;
        if (s >= hd) begin w = s - hd; m -= 1; end
        else w = s;
      end
    end
    return m;
  endfunction

  // Drives one operation; optional intruding start with other operands at cycle 5
  task automatic run_op(input logic [31:0] a, input logic [15:0] d, input bit intrude,
                        output int lat);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = d;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (intrude && lat == 5) begin
        start = 1'b1; dividend = 32'h0000_0003; divisor = 16'h0000;
      end
      if (done) break;
      if (lat > 400) begin
        chk(1'b0, "R4", "no done", lat, 0);
        break;
      end
    end
    start = 1'b0;
  endtask

  task automatic t_timed(input logic [31:0] a, input logic [15:0] d);
    int lat, m;
    m = exp_micro(a, d);
    run_op(a, d, 1'b0, lat);
    chk(lat == 2*m, "R4", "latency", lat, 2*m);
    chk(cycle_count == 8'(2*m - 4), "R5", "cycle_count", cycle_count, 2*m - 4);
    chk(quotient == 16'(a / d), "R3", "quotient", quotient, a / d);
    chk(remainder == 16'(a % d), "R3", "remainder", remainder, a % d);
    chk(result == {16'(a % d), 16'(a / d)}, "R3", "packed result", result,
        {16'(a % d), 16'(a / d)});
    chk(!overflow && !div_zero, "R6", "flags clear", {overflow, div_zero}, 0);
    @(negedge clk);
    chk(!done, "R6", "done width", done, 0);
  endtask

  task automatic t_worst;
    int lat;
    run_op(32'h0, 16'h1, 1'b0, lat);
    chk(lat == 136, "R5", "worst latency", lat, 136);
    chk(cycle_count == 8'd132, "R5", "worst cycle_count", cycle_count, 132);
    chk(quotient == 16'h0 && remainder == 16'h0, "R3", "zero dividend", result, 0);
  endtask

  task automatic t_zero;
    int lat;
    logic [31:0] prev;
    prev = result;
    run_op(32'h0000_0005, 16'h0, 1'b0, lat);
    chk(lat == 1, "R1", "zero latency", lat, 1);
    chk(div_zero && !overflow, "R1", "zero flags", {div_zero, overflow}, 2);
    chk(cycle_count == 8'd0, "R1", "zero cycle_count", cycle_count, 0);
    chk(result == prev, "R1", "results held", result, prev);
  endtask

  task automatic t_overflow;
    int lat;
    logic [31:0] prev;
    prev = result;
    run_op(32'h0005_0000, 16'h5, 1'b0, lat);
    chk(lat == 10, "R2", "overflow latency", lat, 10);
    chk(overflow && !div_zero, "R2", "overflow flags", {overflow, div_zero}, 2);
    chk(cycle_count == 8'd6, "R2", "overflow cycle_count", cycle_count, 6);
    chk(result == prev, "R2", "results held", result, prev);
  endtask

  task automatic t_ovf_edge;
    int lat, m;
    m = exp_micro(32'h0004_FFFF, 16'h5);
    run_op(32'h0004_FFFF, 16'h5, 1'b0, lat);
    chk(!overflow, "R2", "upper one below divisor is not overflow", overflow, 0);
    chk(quotient == 16'hFFFF && remainder == 16'd4, "R3", "boundary result", result,
        {16'd4, 16'hFFFF});
    chk(lat == 2*m, "R4", "boundary latency", lat, 2*m);
  endtask

  task automatic t_busy_ignore;
    int lat, m, extra;
    m = exp_micro(32'd1000, 16'd3);
    run_op(32'd1000, 16'd3, 1'b1, lat);
    chk(lat == 2*m, "R7", "latency with intruding start", lat, 2*m);
    chk(quotient == 16'd333 && remainder == 16'd1, "R7", "first operation result",
        result, {16'd1, 16'd333});
    chk(!div_zero, "R7", "intruding zero divisor ignored", div_zero, 0);
    extra = 0;
    repeat (200) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R7", "no second done", extra, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!done && result == 0 && !div_zero && !overflow && cycle_count == 0,
        "R8", "outputs in reset", result, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && result == 0 && cycle_count == 0, "R8", "outputs after reset", result, 0);
    t_timed(32'd100, 16'd7);
    t_timed(32'h1234_5678, 16'h9ABC);
    t_timed(32'hFFFE_FFFF, 16'hFFFF);
    t_timed(32'h7FFF_FFFF, 16'h8000);
    t_worst();
    t_zero();
    t_timed(32'd77777, 16'd123);
    t_overflow();
    t_ovf_edge();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1200000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule